// File: doc/BRIEF.md
# Sort-Banyan Self-Routing Packet Fabric

This block is an 8-port slotted cell switch. In every time slot each input port may present one fixed-length cell: a valid flag, a 3-bit output address and a payload. All cells of a slot move through the fabric together as one wide word, and each pipeline stage is registered. Each delivered cell leaves on the output port named by its address, and it carries its payload and the index of the input port it came from.

A banyan network on its own blocks when cells collide inside it. To avoid this, the cells first pass through a bitonic sorting network built from compare-exchange elements. Each cell's sort key has an activity bit at the top (0 active, 1 idle), then the address, then the source port index. After the sort, active cells are packed at the top of the word in ascending address order. Cells with the same address sit next to each other, and the one nearest the top of each such run wins. The other cells of the run are dropped and reported on a per-source lost flag. The winners are then packed into a gap-free prefix. That prefix enters a three-stage shuffle-exchange network of 2x2 self-routing elements. Inputs that are packed and whose addresses are distinct and ascending never contend in that network.

A downstream queue manager or retry stage can use the lost flags to hold cells or drop them. The fabric itself does not store cells from one slot to the next.

Top module: `sort_banyan_fabric`

## Requirements
- R1: While rst_ni is low, and in the first cycles after it rises, every out_valid_o bit and every lost_o bit is 0.
- R2: Latency is fixed at 10 clocks: 6 sorter columns, 1 packing stage and 3 routing stages. A slot captured on one rising edge appears on the outputs after the 10th following rising edge. A new slot can be accepted on every clock.
- R3: Input port i is active when in_valid_i[i] is 1. Its address is in_dest_i[3*i+2:3*i] and its payload is in_pld_i[16*i+15:16*i]. If the address d of an active cell is shared by no other active cell in its slot, then output d shows out_valid_o[d]=1, the payload in out_pld_o[16*d+15:16*d], and i in out_src_o[3*d+2:3*d]. This holds for any set of active inputs, whether scattered or contiguous.
- R4: When several active cells in a slot share an address, only the one on the lowest-numbered input port is delivered.
- R5: Every other active cell of such a group raises lost_o at its source index, in the same cycle as that slot's outputs. lost_o is never set for a delivered cell or an idle input.
- R6: An idle input never affects delivery or loss for its slot, whatever its address and payload.
- R7: An output port that no active cell addresses shows out_valid_o low. No output port receives more than one cell per slot.
- R8: The sorter output is ordered ascending by the key {idle bit, address, source index}, so active cells sit above idle ones.
- R9: Cells that enter the routing stages form a gap-free prefix with strictly ascending addresses. Each 2x2 element routes on one address bit, most significant bit first: 0 goes to the upper output and 1 to the lower. Two valid cells never request the same element output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 8 | Per-input cell present flag |
| in_dest_i | input | 24 | Per-input output address, 3 bits each |
| in_pld_i | input | 128 | Per-input payload, 16 bits each |
| out_valid_o | output | 8 | Per-output cell delivered flag |
| out_pld_o | output | 128 | Per-output payload, 16 bits each |
| out_src_o | output | 24 | Per-output source port index, 3 bits each |
| lost_o | output | 8 | Per-input flag: the cell lost contention |

## Verification
The hardest case to reach from the ports is a slot where the sort result must be packed before it is routed. This happens when duplicate addresses leave gaps among the winners, or when idle inputs with low indices carry the same addresses as active cells further down. If either of these is mishandled, the cells collide silently inside the routing stages. The stimulus therefore includes several kinds of slot: rotations of full permutations, random masks over random permutations, and many slots with random repeated addresses. It also includes slots where low-index idle inputs shadow the addresses of active cells. A behavioural model in the bench picks the lowest-index winner for each address and compares every port on every clock. The assertions inside the 2x2 elements catch any contention directly.

// File: rtl/sb_pkg.sv
package sb_pkg;

  function automatic int sort_cols(input int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // column of merge phase p, half-distance 2**q
  function automatic int col_index(input int p, input int q);
    return p * (p + 1) / 2 + (p - q);
  endfunction

  function automatic int shuffle_idx(input int i, input int lg);
    return ((i << 1) | (i >> (lg - 1))) & ((1 << lg) - 1);
  endfunction

endpackage

// File: rtl/sb_cmp_exch.sv
module sb_cmp_exch #(
  parameter int CW  = 23,
  parameter int KW  = 7,
  parameter bit ASC = 1'b1
) (
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  output logic [CW-1:0] up_o,
  output logic [CW-1:0] dn_o
);
  logic a_gt;
  assign a_gt = a_i[CW-1 -: KW] > b_i[CW-1 -: KW];

  if (ASC) begin : g_asc
    assign up_o = a_gt ? b_i : a_i;
    assign dn_o = a_gt ? a_i : b_i;
  end else begin : g_desc
    assign up_o = a_gt ? a_i : b_i;
    assign dn_o = a_gt ? b_i : a_i;
  end
endmodule

// File: rtl/sb_bitonic_sorter.sv
module sb_bitonic_sorter #(
  parameter int N  = 8,
  parameter int CW = 23,
  parameter int KW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cells_i [N],
  output logic [CW-1:0] cells_o [N]
);
  localparam int LG   = $clog2(N);
  localparam int NCOL = sb_pkg::sort_cols(LG);
  localparam logic [CW-1:0] IDLE = {1'b1, {(CW-1){1'b0}}};

  logic [CW-1:0] col_in [NCOL][N];
  logic [CW-1:0] nxt    [NCOL][N];
  logic [CW-1:0] cur    [NCOL][N];

  for (genvar c = 0; c < NCOL; c++) begin : g_feed
    for (genvar i = 0; i < N; i++) begin : g_el
      if (c == 0) begin : g_first
        assign col_in[c][i] = cells_i[i];
      end else begin : g_next
        assign col_in[c][i] = cur[c-1][i];
      end
    end
  end

  for (genvar p = 0; p < LG; p++) begin : g_merge
    for (genvar d = 0; d <= p; d++) begin : g_col
      localparam int Q = p - d;
      localparam int C = sb_pkg::col_index(p, Q);
      for (genvar i = 0; i < N; i++) begin : g_pair
        localparam int J = i ^ (1 << Q);
        if (J > i) begin : g_ce
          sb_cmp_exch #(
            .CW (CW),
            .KW (KW),
            .ASC(((i >> (p + 1)) & 1) == 0)
          ) u_ce (
            .a_i (col_in[C][i]),
            .b_i (col_in[C][J]),
            .up_o(nxt[C][i]),
            .dn_o(nxt[C][J])
          );
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCOL; c++)
        for (int i = 0; i < N; i++) cur[c][i] <= IDLE;
    end else begin
      for (int c = 0; c < NCOL; c++)
        for (int i = 0; i < N; i++) cur[c][i] <= nxt[c][i];
    end
  end

  assign cells_o = cur[NCOL-1];

  for (genvar i = 1; i < N; i++) begin : g_chk
    p_sorted_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cells_o[i-1][CW-1 -: KW] <= cells_o[i][CW-1 -: KW]);
  end
endmodule

// File: rtl/sb_concentrate.sv
module sb_concentrate #(
  parameter int N  = 8,
  parameter int AW = 3,
  parameter int CW = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cells_i [N],
  output logic [CW-1:0] cells_o [N],
  output logic [N-1:0]  lost_o
);
  localparam int LG = $clog2(N);
  localparam logic [CW-1:0] IDLE = {1'b1, {(CW-1){1'b0}}};

  logic [CW-1:0] pack_n [N];
  logic [N-1:0]  lost_n;
  logic [LG-1:0] wptr;
  logic          prev_act, act, dup;
  logic [AW-1:0] prev_dest, dst, src;

  // sorted input: equal addresses are adjacent, first of each run wins
  always_comb begin
    for (int o = 0; o < N; o++) pack_n[o] = IDLE;
    lost_n    = '0;
    wptr      = '0;
    prev_act  = 1'b0;
    prev_dest = '0;
    act       = 1'b0;
    dup       = 1'b0;
    dst       = '0;
    src       = '0;
    for (int j = 0; j < N; j++) begin
      act = !cells_i[j][CW-1];
      dst = cells_i[j][CW-2 -: AW];
      src = cells_i[j][CW-2-AW -: AW];
      dup = act && prev_act && (dst == prev_dest);
      if (act && !dup) begin
        pack_n[wptr] = cells_i[j];
        wptr         = wptr + 1'b1;
      end
      if (dup) lost_n[src] = 1'b1;
      prev_act  = act;
      prev_dest = dst;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < N; o++) cells_o[o] <= IDLE;
      lost_o <= '0;
    end else begin
      for (int o = 0; o < N; o++) cells_o[o] <= pack_n[o];
      lost_o <= lost_n;
    end
  end

  for (genvar o = 1; o < N; o++) begin : g_chk
    p_concentrated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cells_o[o-1][CW-1] |-> cells_o[o][CW-1]);
    p_rising_dest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cells_o[o][CW-1] |-> (cells_o[o-1][CW-2 -: AW] < cells_o[o][CW-2 -: AW]));
  end
endmodule

// File: rtl/sb_switch2.sv
module sb_switch2 #(
  parameter int CW  = 23,
  parameter int AW  = 3,
  parameter int BIT = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  output logic [CW-1:0] up_o,
  output logic [CW-1:0] dn_o
);
  localparam int POS = CW - 1 - AW + BIT;
  localparam logic [CW-1:0] IDLE = {1'b1, {(CW-1){1'b0}}};

  logic          a_v, b_v;
  logic [CW-1:0] up_n, dn_n;

  assign a_v = !a_i[CW-1];
  assign b_v = !b_i[CW-1];

  always_comb begin
    up_n = IDLE;
    dn_n = IDLE;
    if (b_v) begin
      if (b_i[POS]) dn_n = b_i;
      else          up_n = b_i;
    end
    if (a_v) begin
      if (a_i[POS]) dn_n = a_i;
      else          up_n = a_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= IDLE;
      dn_o <= IDLE;
    end else begin
      up_o <= up_n;
      dn_o <= dn_n;
    end
  end

  p_no_contention_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_v && b_v) |-> (a_i[POS] != b_i[POS]));
  p_upper_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_v && !a_i[POS]) |=> (up_o == $past(a_i)));
  p_lower_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_v && b_i[POS]) |=> (dn_o == $past(b_i)));
endmodule

// File: rtl/sb_banyan.sv
module sb_banyan #(
  parameter int N  = 8,
  parameter int AW = 3,
  parameter int CW = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cells_i [N],
  output logic [CW-1:0] cells_o [N]
);
  logic [CW-1:0] stg_in  [AW][N];
  logic [CW-1:0] shf     [AW][N];
  logic [CW-1:0] stg_out [AW][N];

  for (genvar s = 0; s < AW; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_wire
      localparam int SH = sb_pkg::shuffle_idx(i, AW);
      if (s == 0) begin : g_first
        assign stg_in[s][i] = cells_i[i];
      end else begin : g_next
        assign stg_in[s][i] = stg_out[s-1][i];
      end
      assign shf[s][SH] = stg_in[s][i];
    end
    for (genvar e = 0; e < N / 2; e++) begin : g_elem
      sb_switch2 #(
        .CW (CW),
        .AW (AW),
        .BIT(AW - 1 - s)
      ) u_sw (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .a_i   (shf[s][2*e]),
        .b_i   (shf[s][2*e+1]),
        .up_o  (stg_out[s][2*e]),
        .dn_o  (stg_out[s][2*e+1])
      );
    end
  end

  assign cells_o = stg_out[AW-1];
endmodule

// File: rtl/sort_banyan_fabric.sv
module sort_banyan_fabric #(
  parameter int NUM_PORTS = 8,
  parameter int PLD_W     = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS-1:0]           in_valid_i,
  input  logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] in_dest_i,
  input  logic [NUM_PORTS*PLD_W-1:0]     in_pld_i,
  output logic [NUM_PORTS-1:0]           out_valid_o,
  output logic [NUM_PORTS*PLD_W-1:0]     out_pld_o,
  output logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0] out_src_o,
  output logic [NUM_PORTS-1:0]           lost_o
);
  localparam int N  = NUM_PORTS;
  localparam int AW = $clog2(N);
  localparam int KW = 1 + 2 * AW;
  localparam int CW = KW + PLD_W;

  logic [CW-1:0] in_cells   [N];
  logic [CW-1:0] sorted     [N];
  logic [CW-1:0] packed_c   [N];
  logic [CW-1:0] routed     [N];
  logic [N-1:0]  conc_lost;
  logic [N-1:0]  lost_pipe  [AW];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign in_cells[i] = {!in_valid_i[i], in_dest_i[i*AW +: AW], AW'(i),
                          in_pld_i[i*PLD_W +: PLD_W]};
  end

  sb_bitonic_sorter #(.N(N), .CW(CW), .KW(KW)) u_sort (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cells_i(in_cells),
    .cells_o(sorted)
  );

  sb_concentrate #(.N(N), .AW(AW), .CW(CW)) u_conc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cells_i(sorted),
    .cells_o(packed_c),
    .lost_o (conc_lost)
  );

  sb_banyan #(.N(N), .AW(AW), .CW(CW)) u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cells_i(packed_c),
    .cells_o(routed)
  );

  // keep loss flags aligned with the routing stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < AW; k++) lost_pipe[k] <= '0;
    end else begin
      lost_pipe[0] <= conc_lost;
      for (int k = 1; k < AW; k++) lost_pipe[k] <= lost_pipe[k-1];
    end
  end
  assign lost_o = lost_pipe[AW-1];

  for (genvar o = 0; o < N; o++) begin : g_out
    assign out_valid_o[o]               = !routed[o][CW-1];
    assign out_src_o[o*AW +: AW]        = routed[o][CW-2-AW -: AW];
    assign out_pld_o[o*PLD_W +: PLD_W]  = routed[o][PLD_W-1:0];

    p_dest_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] |-> (routed[o][CW-2 -: AW] == AW'(o)));
    p_winner_not_lost_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] |-> !lost_o[out_src_o[o*AW +: AW]]);
  end
endmodule

// File: tb/sort_banyan_fabric_tb.sv
module sort_banyan_fabric_tb;
  localparam int N   = 8;
  localparam int PW  = 16;
  localparam int AW  = 3;
  localparam int LAT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    in_valid;
  logic [N*AW-1:0] in_dest;
  logic [N*PW-1:0] in_pld;
  logic [N-1:0]    out_valid;
  logic [N*PW-1:0] out_pld;
  logic [N*AW-1:0] out_src;
  logic [N-1:0]    lost;

  always #5 clk = ~clk;

  sort_banyan_fabric #(.NUM_PORTS(N), .PLD_W(PW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_dest_i  (in_dest),
    .in_pld_i   (in_pld),
    .out_valid_o(out_valid),
    .out_pld_o  (out_pld),
    .out_src_o  (out_src),
    .lost_o     (lost)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [N-1:0]  cv;
  logic [AW-1:0] cd [N];
  logic [PW-1:0] cp [N];

  logic [N-1:0]    qv [$];
  logic [N-1:0]    ql [$];
  logic [N*PW-1:0] qp [$];
  logic [N*AW-1:0] qs [$];
  string           qt [$];

  task automatic check(input string tag, input string what, input int port,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s port %0d: actual %0h expected %0h", tag, what, port, act, exp);
    end
  endtask

  // reference: per address, lowest active input wins; the rest are lost
  task automatic push_expect(input string tag);
    logic [N-1:0]    ev = '0;
    logic [N-1:0]    el = '0;
    logic [N*PW-1:0] ep = '0;
    logic [N*AW-1:0] es = '0;
    int win [N];
    for (int o = 0; o < N; o++) win[o] = -1;
    for (int i = 0; i < N; i++)
      if (cv[i] && win[cd[i]] < 0) win[cd[i]] = i;
    for (int o = 0; o < N; o++) begin
      if (win[o] >= 0) begin
        ev[o] = 1'b1;
        ep[o*PW +: PW] = cp[win[o]];
        es[o*AW +: AW] = AW'(win[o]);
      end
    end
    for (int i = 0; i < N; i++)
      if (cv[i] && win[cd[i]] != i) el[i] = 1'b1;
    qv.push_back(ev); ql.push_back(el); qp.push_back(ep); qs.push_back(es); qt.push_back(tag);
  endtask

  task automatic compare_front();
    logic [N-1:0]    ev = qv.pop_front();
    logic [N-1:0]    el = ql.pop_front();
    logic [N*PW-1:0] ep = qp.pop_front();
    logic [N*AW-1:0] es = qs.pop_front();
    string           tg = qt.pop_front();
    for (int o = 0; o < N; o++) begin
      check(tg, "valid", o, out_valid[o], ev[o]);
      if (ev[o]) begin
        check(tg, "src", o, out_src[o*AW +: AW], es[o*AW +: AW]);
        check(tg, "payload", o, out_pld[o*PW +: PW], ep[o*PW +: PW]);
      end
      check(tg, "lost", o, lost[o], el[o]);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    push_expect(tag);
    if (qt.size() > LAT) compare_front();
    in_valid = cv;
    for (int i = 0; i < N; i++) begin
      in_dest[i*AW +: AW] = cd[i];
      in_pld[i*PW +: PW]  = cp[i];
    end
  endtask

  task automatic set_idle();
    cv = '0;
    for (int i = 0; i < N; i++) begin
      cd[i] = AW'($urandom_range(N - 1, 0));
      cp[i] = PW'($urandom);
    end
  endtask

  task automatic rand_perm();
    for (int i = 0; i < N; i++) cd[i] = AW'(i);
    for (int i = N - 1; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      logic [AW-1:0] t = cd[i];
      cd[i] = cd[j];
      cd[j] = t;
    end
    for (int i = 0; i < N; i++) cp[i] = PW'($urandom);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    in_valid = '0;
    in_dest  = '0;
    in_pld   = '0;
    cv = '0;
    for (int i = 0; i < N; i++) begin cd[i] = '0; cp[i] = '0; end
    repeat (LAT) push_expect("R1 reset flush");

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid_all", -1, out_valid, 0);
    check("R1", "lost_all", -1, lost, 0);
    rst_n = 1'b1;

    // R2: one isolated cell must appear exactly LAT cycles later
    set_idle();
    cv[3] = 1'b1; cd[3] = 3'd6; cp[3] = 16'hbeef;
    step("R2 single cell");
    set_idle();
    repeat (4) step("R2 gap");
    cv[0] = 1'b1; cd[0] = 3'd7; cp[0] = 16'h1234;
    step("R2 back-to-back a");
    cv = '1; for (int i = 0; i < N; i++) begin cd[i] = AW'(i); cp[i] = PW'(16'h100 + i); end
    step("R2 back-to-back b");

    // R3: full permutations
    for (int k = 0; k < N; k++) begin
      cv = '1;
      for (int i = 0; i < N; i++) begin cd[i] = AW'((i + k) % N); cp[i] = PW'($urandom); end
      step("R3 rotation");
    end
    cv = '1;
    for (int i = 0; i < N; i++) begin cd[i] = AW'(N - 1 - i); cp[i] = PW'($urandom); end
    step("R3 reverse");

    // R3 R8 R9: scattered active inputs, distinct addresses
    repeat (40) begin
      rand_perm();
      cv = N'($urandom);
      step("R3 R8 R9 scattered");
    end

    // R4 R5: shared addresses
    cv = '1;
    for (int i = 0; i < N; i++) begin cd[i] = 3'd5; cp[i] = PW'($urandom); end
    step("R4 R5 all same");
    for (int i = 0; i < N; i++) cd[i] = AW'(i / 2);
    step("R4 R5 pairs");
    cv = 8'b1011_0110;
    for (int i = 0; i < N; i++) cd[i] = 3'd2;
    step("R4 R5 sparse group");
    repeat (40) begin
      cv = N'($urandom);
      for (int i = 0; i < N; i++) begin
        cd[i] = AW'($urandom_range(N - 1, 0));
        cp[i] = PW'($urandom);
      end
      step("R4 R5 random repeats");
    end

    // R6: idle inputs shadow addresses of active ones
    cv = 8'b1111_0000;
    for (int i = 0; i < N; i++) begin cd[i] = AW'(i % 4); cp[i] = PW'($urandom); end
    step("R6 idle shadow");
    set_idle();
    step("R6 all idle garbage");
    cv = 8'b0100_0000;
    for (int i = 0; i < N; i++) cd[i] = 3'd1;
    step("R6 one active among idle twins");

    // R7: sparse slot leaves most outputs empty
    set_idle();
    cv[2] = 1'b1; cd[2] = 3'd0;
    step("R7 sparse");

    set_idle();
    repeat (LAT + 2) step("R7 flush");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule